// File: doc/BRIEF.md
# Path-Associative Trace Cache

This block holds trace lines, which are runs of instructions in dynamic execution order that can span several branches, and returns one line per fetch. The array is split into sets selected by the fetch address. Each set holds several ways. Two ways in the same set may carry the same start address, because they are told apart by the branch-direction vector recorded with each line. A fetch presents an address and up to three predicted directions in the same cycle. A way hits only when its tag matches and every direction it recorded agrees with the prediction for that position. Prediction bits beyond the line's own branch count are not looked at.

A fill unit writes finished traces through a separate port. If a fill matches an existing line on address, branch count and recorded directions, it overwrites that line in place. Otherwise it takes an empty way in the set, or the least-recently-used way when the set is full. Both hits and fills refresh a way's recency.

The lookup result appears one cycle after the fetch. It carries the instruction words, the instruction count and the address to fetch next. A miss is flagged with a zero count.

Top module: `trace_cache`

## Requirements
- R1: After reset no line is valid, so every fetch misses until a fill has been written.
- R2: Each fetch cycle produces exactly one response, on `resp_valid_o` in the following cycle. No response appears in any other cycle.
- R3: A hit sets `hit_o` and returns the stored count, all stored instruction words and the stored next-fetch address of the selected line.
- R4: A miss sets `miss_o`, clears `hit_o` and returns a count of zero.
- R5: The set index is address bits [IDX_W+1:2] and the tag is the bits above it. A line whose index matches but whose tag differs does not hit.
- R6: Direction bit k refers to the k-th branch of the trace (bit 0 is the first, 1 means taken). A line is returned only when all of its recorded directions equal the predictions; one wrong direction among several gives a miss, never a partial line.
- R7: Prediction bits at positions at or above the line's branch count are ignored. A line with no branches hits for any prediction.
- R8: Lines with the same start address but different direction vectors occupy separate ways, and the prediction selects between them.
- R9: A fill whose address, branch count and recorded directions equal those of a valid way rewrites that way, and no other line in the set is displaced.
- R10: Any other fill goes to the lowest empty way of the set, or to its least-recently-used way when the set is full. A hit or a fill makes that way the most recent.
- R11: Address bits [1:0] are ignored, so addresses that differ only in those bits return the same line.
- R12: A fetch and a fill in the same cycle see the array as it was before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Lookup request |
| fetch_addr_i | input | AW | Fetch address |
| fetch_pred_i | input | 3 | Predicted directions, bit 0 = first branch |
| fill_valid_i | input | 1 | Write a trace line |
| fill_addr_i | input | AW | Start address of the trace |
| fill_dirs_i | input | 3 | Recorded branch directions |
| fill_nbr_i | input | 2 | Number of branches in the trace (0 to 3) |
| fill_count_i | input | CNT_W | Number of instructions (1 to INSNS) |
| fill_insns_i | input | INSNS*IW | Instruction words, word 0 in the low bits |
| fill_next_i | input | AW | Next-fetch address after the trace |
| resp_valid_o | output | 1 | Response for the previous cycle's fetch |
| hit_o | output | 1 | Line found |
| miss_o | output | 1 | No matching line |
| resp_count_o | output | CNT_W | Instruction count, zero on a miss |
| resp_insns_o | output | INSNS*IW | Instruction words of the hit line |
| resp_next_o | output | AW | Next-fetch address of the hit line |

## Verification
The assertions take the fill port to be well formed. Every fill carries a count between 1 and the line capacity and a branch count no greater than three, so a hit with a zero count can only come from a design fault. The single-oldest check in the recency state also relies on the set never changing other than through one touch per cycle. The stimulus writes only such lines, with distinct tags or distinct paths per set. It never stores two lines that could both match one prediction, so the way chosen on a hit is always unique.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int unsigned MAX_BR = 3;
  localparam int unsigned NBR_W  = $clog2(MAX_BR + 1);

  typedef logic [MAX_BR-1:0] dir_t;
  typedef logic [NBR_W-1:0]  nbr_t;

  // directions that take part in a compare for a line with n branches
  function automatic dir_t br_mask(nbr_t n);
    return dir_t'((32'd1 << n) - 32'd1);
  endfunction
endpackage

// File: rtl/tc_path_match.sv
module tc_path_match
  import tc_pkg::*;
#(
  parameter int unsigned TAG_W = 23
) (
  input  logic             valid_i,
  input  logic [TAG_W-1:0] line_tag_i,
  input  dir_t             line_dirs_i,
  input  nbr_t             line_nbr_i,
  input  logic [TAG_W-1:0] probe_tag_i,
  input  dir_t             probe_dirs_i,
  input  nbr_t             probe_nbr_i,
  output logic             match_o
);
  dir_t mask;
  logic path_ok;

  always_comb begin
    mask    = br_mask(line_nbr_i);
    path_ok = ((line_dirs_i ^ probe_dirs_i) & mask) == '0;
    match_o = valid_i && (line_tag_i == probe_tag_i) && path_ok &&
              (line_nbr_i == probe_nbr_i);
  end
endmodule

// File: rtl/tc_way_store.sv
module tc_way_store
  import tc_pkg::*;
#(
  parameter int unsigned SETS   = 128,
  parameter int unsigned TAG_W  = 23,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned DATA_W = 512,
  parameter int unsigned AW     = 32,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  dir_t              wr_dirs_i,
  input  nbr_t              wr_nbr_i,
  input  logic [CNT_W-1:0]  wr_cnt_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [AW-1:0]     wr_next_i,
  input  logic [IDX_W-1:0]  a_idx_i,
  output logic              a_valid_o,
  output logic [TAG_W-1:0]  a_tag_o,
  output dir_t              a_dirs_o,
  output nbr_t              a_nbr_o,
  output logic [CNT_W-1:0]  a_cnt_o,
  output logic [DATA_W-1:0] a_data_o,
  output logic [AW-1:0]     a_next_o,
  input  logic [IDX_W-1:0]  b_idx_i,
  output logic              b_valid_o,
  output logic [TAG_W-1:0]  b_tag_o,
  output dir_t              b_dirs_o,
  output nbr_t              b_nbr_o
);
  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  dir_t              dirs_q [SETS];
  nbr_t              nbr_q  [SETS];
  logic [CNT_W-1:0]  cnt_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];
  logic [AW-1:0]     next_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else if (we_i) vld_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      dirs_q[wr_idx_i] <= wr_dirs_i;
      nbr_q[wr_idx_i]  <= wr_nbr_i;
      cnt_q[wr_idx_i]  <= wr_cnt_i;
      data_q[wr_idx_i] <= wr_data_i;
      next_q[wr_idx_i] <= wr_next_i;
    end
  end

  // asynchronous read: same-cycle writes are not visible
  assign a_valid_o = vld_q[a_idx_i];
  assign a_tag_o   = tag_q[a_idx_i];
  assign a_dirs_o  = dirs_q[a_idx_i];
  assign a_nbr_o   = nbr_q[a_idx_i];
  assign a_cnt_o   = cnt_q[a_idx_i];
  assign a_data_o  = data_q[a_idx_i];
  assign a_next_o  = next_q[a_idx_i];

  assign b_valid_o = vld_q[b_idx_i];
  assign b_tag_o   = tag_q[b_idx_i];
  assign b_dirs_o  = dirs_q[b_idx_i];
  assign b_nbr_o   = nbr_q[b_idx_i];
endmodule

// File: rtl/tc_lru.sv
module tc_lru #(
  parameter int unsigned SETS = 128,
  parameter int unsigned WAYS = 4,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [IDX_W-1:0] q_idx_i,
  input  logic [WAYS-1:0]  q_valid_i,
  output logic [WAY_W-1:0] victim_o
);
  // per-way age, 0 = most recent, WAYS-1 = oldest; a permutation per set
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAYS-1:0]  oldest_mask;
  logic             found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[touch_idx_i][w] <= '0;
        else if (age_q[touch_idx_i][w] < age_q[touch_idx_i][touch_way_i])
          age_q[touch_idx_i][w] <= age_q[touch_idx_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++)
      oldest_mask[w] = (age_q[q_idx_i][w] == WAY_W'(WAYS - 1));
    victim_o = '0;
    found    = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!q_valid_i[w] && !found) begin
        victim_o = WAY_W'(w);
        found    = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++)
        if (oldest_mask[w]) victim_o = WAY_W'(w);
    end
  end

  // R10
  lru_single_oldest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(oldest_mask) == 1);
endmodule

// File: rtl/trace_cache.sv
module trace_cache
  import tc_pkg::*;
#(
  parameter int unsigned SETS  = 128,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned INSNS = 16,
  parameter int unsigned IW    = 32,
  parameter int unsigned AW    = 32,
  localparam int unsigned IDX_W  = $clog2(SETS),
  localparam int unsigned IDX_LO = 2,
  localparam int unsigned TAG_W  = AW - IDX_W - IDX_LO,
  localparam int unsigned CNT_W  = $clog2(INSNS + 1),
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned DATA_W = INSNS * IW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [AW-1:0]     fetch_addr_i,
  input  logic [2:0]        fetch_pred_i,
  input  logic              fill_valid_i,
  input  logic [AW-1:0]     fill_addr_i,
  input  logic [2:0]        fill_dirs_i,
  input  logic [1:0]        fill_nbr_i,
  input  logic [CNT_W-1:0]  fill_count_i,
  input  logic [DATA_W-1:0] fill_insns_i,
  input  logic [AW-1:0]     fill_next_i,
  output logic              resp_valid_o,
  output logic              hit_o,
  output logic              miss_o,
  output logic [CNT_W-1:0]  resp_count_o,
  output logic [DATA_W-1:0] resp_insns_o,
  output logic [AW-1:0]     resp_next_o
);
  logic [IDX_W-1:0] f_idx, w_idx;
  logic [TAG_W-1:0] f_tag, w_tag;
  logic             unused_lo;

  assign f_idx     = fetch_addr_i[IDX_LO +: IDX_W];
  assign f_tag     = fetch_addr_i[AW-1 -: TAG_W];
  assign w_idx     = fill_addr_i[IDX_LO +: IDX_W];
  assign w_tag     = fill_addr_i[AW-1 -: TAG_W];
  assign unused_lo = ^{fetch_addr_i[IDX_LO-1:0], fill_addr_i[IDX_LO-1:0]};

  logic [WAYS-1:0]   hit_vec, fm_vec, fv_vec, we_vec;
  logic [CNT_W-1:0]  rd_cnt  [WAYS];
  logic [DATA_W-1:0] rd_data [WAYS];
  logic [AW-1:0]     rd_next [WAYS];
  logic [WAY_W-1:0]  fill_way;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic             a_valid, b_valid;
    logic [TAG_W-1:0] a_tag, b_tag;
    dir_t             a_dirs, b_dirs;
    nbr_t             a_nbr, b_nbr;

    assign we_vec[w] = fill_valid_i && (fill_way == WAY_W'(w));

    tc_way_store #(
      .SETS(SETS), .TAG_W(TAG_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .AW(AW)
    ) i_store (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (we_vec[w]),
      .wr_idx_i  (w_idx),
      .wr_tag_i  (w_tag),
      .wr_dirs_i (fill_dirs_i),
      .wr_nbr_i  (fill_nbr_i),
      .wr_cnt_i  (fill_count_i),
      .wr_data_i (fill_insns_i),
      .wr_next_i (fill_next_i),
      .a_idx_i   (f_idx),
      .a_valid_o (a_valid),
      .a_tag_o   (a_tag),
      .a_dirs_o  (a_dirs),
      .a_nbr_o   (a_nbr),
      .a_cnt_o   (rd_cnt[w]),
      .a_data_o  (rd_data[w]),
      .a_next_o  (rd_next[w]),
      .b_idx_i   (w_idx),
      .b_valid_o (b_valid),
      .b_tag_o   (b_tag),
      .b_dirs_o  (b_dirs),
      .b_nbr_o   (b_nbr)
    );

    // lookup: compare only as many directions as the line holds
    tc_path_match #(.TAG_W(TAG_W)) i_lookup (
      .valid_i      (a_valid),
      .line_tag_i   (a_tag),
      .line_dirs_i  (a_dirs),
      .line_nbr_i   (a_nbr),
      .probe_tag_i  (f_tag),
      .probe_dirs_i (fetch_pred_i),
      .probe_nbr_i  (a_nbr),
      .match_o      (hit_vec[w])
    );

    // fill: same path means same branch count too
    tc_path_match #(.TAG_W(TAG_W)) i_fillm (
      .valid_i      (b_valid),
      .line_tag_i   (b_tag),
      .line_dirs_i  (b_dirs),
      .line_nbr_i   (b_nbr),
      .probe_tag_i  (w_tag),
      .probe_dirs_i (fill_dirs_i),
      .probe_nbr_i  (fill_nbr_i),
      .match_o      (fm_vec[w])
    );

    assign fv_vec[w] = b_valid;
  end

  logic             hit_any;
  logic [WAY_W-1:0] hit_way, fm_way, victim;

  always_comb begin
    hit_way = '0;
    fm_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
      if (fm_vec[w])  fm_way  = WAY_W'(w);
    end
    hit_any  = |hit_vec;
    fill_way = (|fm_vec) ? fm_way : victim;
  end

  logic             touch;
  logic [IDX_W-1:0] touch_idx;
  logic [WAY_W-1:0] touch_way;

  // a fill owns the recency port; a same-cycle hit does not refresh
  assign touch     = fill_valid_i || (fetch_valid_i && hit_any);
  assign touch_idx = fill_valid_i ? w_idx : f_idx;
  assign touch_way = fill_valid_i ? fill_way : hit_way;

  tc_lru #(.SETS(SETS), .WAYS(WAYS)) i_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (touch),
    .touch_idx_i (touch_idx),
    .touch_way_i (touch_way),
    .q_idx_i     (w_idx),
    .q_valid_i   (fv_vec),
    .victim_o    (victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      hit_o        <= 1'b0;
      miss_o       <= 1'b0;
      resp_count_o <= '0;
      resp_insns_o <= '0;
      resp_next_o  <= '0;
    end else begin
      resp_valid_o <= fetch_valid_i;
      hit_o        <= fetch_valid_i && hit_any;
      miss_o       <= fetch_valid_i && !hit_any;
      if (fetch_valid_i) begin
        resp_count_o <= hit_any ? rd_cnt[hit_way] : '0;
        if (hit_any) begin
          resp_insns_o <= rd_data[hit_way];
          resp_next_o  <= rd_next[hit_way];
        end
      end
    end
  end

  // R2
  resp_follows_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i |=> resp_valid_o);
  // R2
  no_spurious_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |=> !resp_valid_o);
  // R4
  miss_zero_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (resp_count_o == '0) && !hit_o && resp_valid_o);
  // R3
  hit_has_insns_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> resp_valid_o && !miss_o && (resp_count_o != '0));
  // R9
  fill_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i |-> $countones(fm_vec) <= 1);
endmodule

// File: tb/test_trace_cache.sv
module test_trace_cache;
  localparam int unsigned DW = 512;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          fetch_valid_i = 1'b0;
  logic [31:0]   fetch_addr_i = '0;
  logic [2:0]    fetch_pred_i = '0;
  logic          fill_valid_i = 1'b0;
  logic [31:0]   fill_addr_i = '0;
  logic [2:0]    fill_dirs_i = '0;
  logic [1:0]    fill_nbr_i = '0;
  logic [4:0]    fill_count_i = '0;
  logic [DW-1:0] fill_insns_i = '0;
  logic [31:0]   fill_next_i = '0;
  logic          resp_valid_o, hit_o, miss_o;
  logic [4:0]    resp_count_o;
  logic [DW-1:0] resp_insns_o;
  logic [31:0]   resp_next_o;

  trace_cache i_trace_cache (
    .clk_i, .rst_ni, .fetch_valid_i, .fetch_addr_i, .fetch_pred_i,
    .fill_valid_i, .fill_addr_i, .fill_dirs_i, .fill_nbr_i, .fill_count_i,
    .fill_insns_i, .fill_next_i, .resp_valid_o, .hit_o, .miss_o,
    .resp_count_o, .resp_insns_o, .resp_next_o
  );

  always #4 clk_i = ~clk_i;

  typedef struct {
    logic        hit;
    logic [4:0]  cnt;
    logic [DW-1:0] ins;
    logic [31:0] nxt;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] mk_ins(input logic [15:0] seed);
    logic [DW-1:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = {seed, 16'(i)};
    return r;
  endfunction

  function automatic logic [31:0] mk_addr(input logic [22:0] tag, input logic [6:0] idx);
    return {tag, idx, 2'b00};
  endfunction

  // monitor: pops one expectation per response
  always @(negedge clk_i) begin
    if (rst_ni && resp_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected response", DW'(1), DW'(0));
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(hit_o == e.hit, {e.req, " hit"}, DW'(hit_o), DW'(e.hit));
        chk(miss_o == !e.hit, {e.req, " miss R4"}, DW'(miss_o), DW'(!e.hit));
        chk(resp_count_o == e.cnt, {e.req, " count"}, DW'(resp_count_o), DW'(e.cnt));
        if (e.hit) begin
          chk(resp_insns_o == e.ins, {e.req, " insns R3"}, resp_insns_o, e.ins);
          chk(resp_next_o == e.nxt, {e.req, " next R3"}, DW'(resp_next_o), DW'(e.nxt));
        end
      end
    end
  end

  task automatic fill(input logic [31:0] a, input logic [2:0] d, input logic [1:0] nb,
                      input logic [4:0] c, input logic [15:0] seed, input logic [31:0] nx);
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_addr_i = a; fill_dirs_i = d; fill_nbr_i = nb;
    fill_count_i = c; fill_insns_i = mk_ins(seed); fill_next_i = nx;
    @(posedge clk_i);
    #1 fill_valid_i = 1'b0;
  endtask

  task automatic push_exp(input bit h, input logic [4:0] c, input logic [15:0] seed,
                          input logic [31:0] nx, input string req);
    exp_t e;
    e.hit = h; e.cnt = h ? c : 5'd0; e.ins = mk_ins(seed); e.nxt = nx; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic fetch(input logic [31:0] a, input logic [2:0] p, input bit h,
                       input logic [4:0] c, input logic [15:0] seed,
                       input logic [31:0] nx, input string req);
    @(negedge clk_i);
    fetch_valid_i = 1'b1; fetch_addr_i = a; fetch_pred_i = p;
    push_exp(h, c, seed, nx, req);
    @(posedge clk_i);
    #1 fetch_valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      chk(1'b0, "watchdog", DW'(0), DW'(1));
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!resp_valid_o && !hit_o && !miss_o, "R1 reset outputs",
        DW'({resp_valid_o, hit_o, miss_o}), DW'(0));

    // R1 empty after reset
    fetch(mk_addr(23'd5, 7'd1), 3'b000, 0, 0, 0, 0, "R1 empty");
    fetch(mk_addr(23'd7, 7'd2), 3'b101, 0, 0, 0, 0, "R1 empty2");

    // R3 / R7 no-branch line hits for any prediction
    fill(mk_addr(23'd7, 7'd2), 3'b000, 2'd0, 5'd16, 16'h11, 32'h1000);
    fetch(mk_addr(23'd7, 7'd2), 3'b101, 1, 16, 16'h11, 32'h1000, "R3 R7 hit");
    fetch(mk_addr(23'd7, 7'd2) | 32'd3, 3'b010, 1, 16, 16'h11, 32'h1000, "R11 low bits");
    fetch(mk_addr(23'd8, 7'd2), 3'b000, 0, 0, 0, 0, "R5 tag differs");

    // R6 all-or-nothing over three branches
    fill(mk_addr(23'd1, 7'd3), 3'b101, 2'd3, 5'd12, 16'h22, 32'h2000);
    fetch(mk_addr(23'd1, 7'd3), 3'b100, 0, 0, 0, 0, "R6 first wrong");
    fetch(mk_addr(23'd1, 7'd3), 3'b001, 0, 0, 0, 0, "R6 third wrong");
    fetch(mk_addr(23'd1, 7'd3), 3'b111, 0, 0, 0, 0, "R6 second wrong");
    fetch(mk_addr(23'd1, 7'd3), 3'b101, 1, 12, 16'h22, 32'h2000, "R6 all agree");

    // R7 one-branch line ignores upper prediction bits
    fill(mk_addr(23'd2, 7'd4), 3'b001, 2'd1, 5'd5, 16'h33, 32'h3000);
    fetch(mk_addr(23'd2, 7'd4), 3'b001, 1, 5, 16'h33, 32'h3000, "R7 exact");
    fetch(mk_addr(23'd2, 7'd4), 3'b111, 1, 5, 16'h33, 32'h3000, "R7 upper ignored");
    fetch(mk_addr(23'd2, 7'd4), 3'b110, 0, 0, 0, 0, "R7 first wrong");

    // R8 two paths from one address
    fill(mk_addr(23'd3, 7'd5), 3'b000, 2'd1, 5'd6, 16'h44, 32'h4000);
    fill(mk_addr(23'd3, 7'd5), 3'b001, 2'd1, 5'd7, 16'h55, 32'h5000);
    fetch(mk_addr(23'd3, 7'd5), 3'b000, 1, 6, 16'h44, 32'h4000, "R8 not-taken path");
    fetch(mk_addr(23'd3, 7'd5), 3'b001, 1, 7, 16'h55, 32'h5000, "R8 taken path");

    // R9 rewrite in place keeps the other lines
    fill(mk_addr(23'd10, 7'd6), 3'b001, 2'd2, 5'd8, 16'h70, 32'h7000);
    fill(mk_addr(23'd11, 7'd6), 3'b000, 2'd0, 5'd3, 16'h71, 32'h7100);
    fill(mk_addr(23'd12, 7'd6), 3'b000, 2'd0, 5'd4, 16'h72, 32'h7200);
    fill(mk_addr(23'd13, 7'd6), 3'b000, 2'd0, 5'd9, 16'h73, 32'h7300);
    fetch(mk_addr(23'd10, 7'd6), 3'b001, 1, 8, 16'h70, 32'h7000, "R9 before");
    fill(mk_addr(23'd10, 7'd6), 3'b001, 2'd2, 5'd10, 16'h7a, 32'h7a00);
    fetch(mk_addr(23'd11, 7'd6), 3'b000, 1, 3, 16'h71, 32'h7100, "R9 neighbour kept");
    fetch(mk_addr(23'd10, 7'd6), 3'b001, 1, 10, 16'h7a, 32'h7a00, "R9 rewritten");
    fetch(mk_addr(23'd12, 7'd6), 3'b000, 1, 4, 16'h72, 32'h7200, "R9 c kept");
    fetch(mk_addr(23'd13, 7'd6), 3'b000, 1, 9, 16'h73, 32'h7300, "R9 d kept");

    // R10 full set evicts least recent, hit refreshes
    fill(mk_addr(23'd20, 7'd7), 3'b000, 2'd0, 5'd1, 16'h80, 32'h8000);
    fill(mk_addr(23'd21, 7'd7), 3'b000, 2'd0, 5'd2, 16'h81, 32'h8100);
    fill(mk_addr(23'd22, 7'd7), 3'b000, 2'd0, 5'd3, 16'h82, 32'h8200);
    fill(mk_addr(23'd23, 7'd7), 3'b000, 2'd0, 5'd4, 16'h83, 32'h8300);
    fetch(mk_addr(23'd20, 7'd7), 3'b000, 1, 1, 16'h80, 32'h8000, "R10 refresh");
    fill(mk_addr(23'd24, 7'd7), 3'b000, 2'd0, 5'd5, 16'h84, 32'h8400);
    fetch(mk_addr(23'd21, 7'd7), 3'b000, 0, 0, 0, 0, "R10 lru evicted");
    fetch(mk_addr(23'd20, 7'd7), 3'b000, 1, 1, 16'h80, 32'h8000, "R10 recent kept");
    fetch(mk_addr(23'd22, 7'd7), 3'b000, 1, 3, 16'h82, 32'h8200, "R10 c kept");
    fetch(mk_addr(23'd23, 7'd7), 3'b000, 1, 4, 16'h83, 32'h8300, "R10 d kept");
    fetch(mk_addr(23'd24, 7'd7), 3'b000, 1, 5, 16'h84, 32'h8400, "R10 new line");

    // R12 same-cycle fetch and fill
    @(negedge clk_i);
    fetch_valid_i = 1'b1; fetch_addr_i = mk_addr(23'd30, 7'd8); fetch_pred_i = 3'b000;
    fill_valid_i = 1'b1; fill_addr_i = mk_addr(23'd30, 7'd8); fill_dirs_i = 3'b000;
    fill_nbr_i = 2'd0; fill_count_i = 5'd2; fill_insns_i = mk_ins(16'h90);
    fill_next_i = 32'h9000;
    push_exp(0, 0, 0, 0, "R12 old contents");
    @(posedge clk_i);
    #1 begin fetch_valid_i = 1'b0; fill_valid_i = 1'b0; end
    fetch(mk_addr(23'd30, 7'd8), 3'b000, 1, 2, 16'h90, 32'h9000, "R12 after fill");

    repeat (4) @(negedge clk_i);
    chk(exp_q.size() == 0, "R2 all responses", DW'(exp_q.size()), DW'(0));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule